// File: doc/BRIEF.md
# Word-Aligned Program Counter Unit

This block keeps the fetch address of a 32-bit processor whose instructions are all one word long and always word-aligned. Since the two lowest address bits can never be anything but zero, the register holds only a 30-bit word count. Two zero bits are appended whenever a byte address leaves the block. Every clock cycle the unit picks the next word count from one of three sources: the plain sequential step, a relative branch target, or the byte address held in a register operand.

A relative branch carries a 16-bit signed offset counted in words. The offset is measured from the word that follows the branch, which is the delay slot. The scaling to bytes costs no shifter, because the offset is added directly into the word count. A register jump takes the operand as an ordinary byte address. Any nonzero low bits in that operand are discarded and reported on a one-cycle flag. The unit also provides a link address two instructions past the current one, for use by call-type instructions.

Top module: `pc_word_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `fetch_addr` reads 0x00400000 and `misalign` reads 0. Reset acts asynchronously.
- R2: Bits 1:0 of `fetch_addr` are always zero.
- R3: When `stall` is 0 and `sel` is 0 (sequential), `fetch_addr` goes up by 4 on the next clock edge.
- R4: When `stall` is 0, `sel` is 1 (branch) and `br_taken` is 1, a branch held at byte address X leads to X + 4 + 4*S on the next edge. S is `br_imm` read as a signed 16-bit word count.
- R5: When `stall` is 0, `sel` is 1 and `br_taken` is 0, `fetch_addr` goes up by 4, whatever `br_imm` holds.
- R6: When `stall` is 0 and `sel` is 2 (register jump), the next `fetch_addr` equals `reg_addr` with bits 1:0 forced to zero. No shift is applied.
- R7: `misalign` is 1 in the cycle that follows an unstalled register jump whose `reg_addr[1:0]` is nonzero. In every other cycle it is 0.
- R8: When `stall` is 1, `fetch_addr` keeps its value on the next edge and `misalign` goes to 0, whatever the other inputs are.
- R9: `link_addr` always equals `fetch_addr` + 8, taken modulo 2^32.
- R10: A `sel` of 3 is handled exactly like sequential.
- R11: All address arithmetic wraps modulo 2^32. Sequential execution from 0xFFFFFFFC continues at 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Hold the current address |
| sel | input | 2 | Next-address source: 0 sequential, 1 branch, 2 register jump, 3 sequential |
| br_taken | input | 1 | Branch condition result |
| br_imm | input | 16 | Signed branch offset in words |
| reg_addr | input | 32 | Register operand used as a byte address |
| fetch_addr | output | 32 | Byte address of the current instruction |
| link_addr | output | 32 | Return address, fetch_addr + 8 |
| misalign | output | 1 | A register jump target had nonzero low bits |

## Verification
The bench sweeps all 65,536 branch offsets, so an adder that drops the sign extension, adds the offset as bytes instead of words, or measures from the branch rather than the delay slot goes to the wrong address on half or all of the sweep. Register jumps are run with every low-bit pattern. A design that shifts the operand would land far away, one that keeps the low bits would return a misaligned address, and one that holds the flag too long would show it on the following sequential step. Stalls are combined with branch and misaligned-jump requests to catch a hold that leaks an update. Runs across the top of the address space catch a link or step that fails to wrap.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
    // Number of address bits that word alignment fixes at zero
    localparam int unsigned PCU_ALIGN = 2;

    // Next-address source selection
    typedef enum logic [1:0] {
        PCU_SEQ    = 2'd0,
        PCU_BRANCH = 2'd1,
        PCU_JREG   = 2'd2,
        PCU_RSVD   = 2'd3
    } pcu_sel_e;
endpackage

// File: rtl/pcu_incr.sv
`timescale 1ns/1ps
// Word-count increments: next word (delay slot) and the one after it (link)
module pcu_incr #(
    parameter int unsigned WORD_W = 30
) (
    input  logic [WORD_W-1:0] word_q,
    output logic [WORD_W-1:0] plus_one,
    output logic [WORD_W-1:0] plus_two
);
    always_comb begin
        plus_one = word_q + WORD_W'(1);
        plus_two = word_q + WORD_W'(2);
    end
endmodule

// File: rtl/pcu_branch_target.sv
`timescale 1ns/1ps
// Relative target: the signed word offset is added to the delay-slot word count.
// Working in word units is what scales the offset by four at no cost.
module pcu_branch_target #(
    parameter int unsigned WORD_W = 30,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [WORD_W-1:0] slot_word,
    input  logic [IMM_W-1:0]  offset,
    output logic [WORD_W-1:0] target_word
);
    logic [WORD_W-1:0] offset_ext;

    generate
        if (WORD_W > IMM_W) begin : g_extend
            assign offset_ext = {{(WORD_W-IMM_W){offset[IMM_W-1]}}, offset};
        end else begin : g_trunc
            assign offset_ext = offset[WORD_W-1:0];
        end
    endgenerate

    assign target_word = slot_word + offset_ext;
endmodule

// File: rtl/pcu_state.sv
`timescale 1ns/1ps
// Word-count register and misalignment flag, in two-process form
module pcu_state
    import pcu_pkg::*;
#(
    parameter int unsigned       WORD_W     = 30,
    parameter logic [WORD_W-1:0] RESET_WORD = 30'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [1:0]        sel,
    input  logic              br_taken,
    input  logic [WORD_W-1:0] slot_word,
    input  logic [WORD_W-1:0] branch_word,
    input  logic [WORD_W-1:0] jump_word,
    input  logic              jump_low_nz,
    output logic [WORD_W-1:0] word_q,
    output logic              misalign_q
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              misalign;
    } pcu_regs_t;

    pcu_regs_t regs_d, regs_q;

    always_comb begin
        regs_d          = regs_q;
        regs_d.misalign = 1'b0;
        if (!stall) begin
            case (pcu_sel_e'(sel))
                PCU_BRANCH: regs_d.word = br_taken ? branch_word : slot_word;
                PCU_JREG: begin
                    regs_d.word     = jump_word;
                    regs_d.misalign = jump_low_nz;
                end
                default:    regs_d.word = slot_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.word     <= RESET_WORD;
            regs_q.misalign <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign word_q     = regs_q.word;
    assign misalign_q = regs_q.misalign;
endmodule

// File: rtl/pc_word_unit.sv
`timescale 1ns/1ps
module pc_word_unit
    import pcu_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       IMM_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [1:0]        sel,
    input  logic              br_taken,
    input  logic [IMM_W-1:0]  br_imm,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] link_addr,
    output logic              misalign
);
    localparam int unsigned       WORD_W     = ADDR_W - PCU_ALIGN;
    localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:PCU_ALIGN];

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] slot_word;
    logic [WORD_W-1:0] link_word;
    logic [WORD_W-1:0] branch_word;

    pcu_incr #(.WORD_W(WORD_W)) u_incr (
        .word_q   (word_q),
        .plus_one (slot_word),
        .plus_two (link_word)
    );

    pcu_branch_target #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_target (
        .slot_word   (slot_word),
        .offset      (br_imm),
        .target_word (branch_word)
    );

    pcu_state #(.WORD_W(WORD_W), .RESET_WORD(RESET_WORD)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .sel         (sel),
        .br_taken    (br_taken),
        .slot_word   (slot_word),
        .branch_word (branch_word),
        .jump_word   (reg_addr[ADDR_W-1:PCU_ALIGN]),
        .jump_low_nz (|reg_addr[PCU_ALIGN-1:0]),
        .word_q      (word_q),
        .misalign_q  (misalign)
    );

    assign fetch_addr = {word_q,    {PCU_ALIGN{1'b0}}};
    assign link_addr  = {link_word, {PCU_ALIGN{1'b0}}};
endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic [1:0]        sel,
    input logic              br_taken,
    input logic [IMM_W-1:0]  br_imm,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] link_addr,
    input logic              misalign
);
    logic [ADDR_W-1:0] byte_off;
    assign byte_off = {{(ADDR_W-IMM_W-2){br_imm[IMM_W-1]}}, br_imm, 2'b00};

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd0) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

    p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd1 && br_taken)
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4) + $past(byte_off));

    p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd1 && !br_taken) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

    p_jreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd2) |=> fetch_addr == {$past(reg_addr[ADDR_W-1:2]), 2'b00});

    p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd2 && reg_addr[1:0] != 2'b00) |=> misalign);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!stall && sel == 2'd2 && reg_addr[1:0] != 2'b00) |=> !misalign);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(fetch_addr) && !misalign);

    p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_addr == fetch_addr + ADDR_W'(8));

    p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sel == 2'd3) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));
endmodule

bind pc_word_unit pcu_checker #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .sel        (sel),
    .br_taken   (br_taken),
    .br_imm     (br_imm),
    .reg_addr   (reg_addr),
    .fetch_addr (fetch_addr),
    .link_addr  (link_addr),
    .misalign   (misalign)
);

// File: tb/sim_pc_word_unit.sv
`timescale 1ns/1ps
module sim_pc_word_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic        br_taken = 1'b0;
    logic [15:0] br_imm = 16'h0;
    logic [31:0] reg_addr = 32'h0;
    logic [31:0] fetch_addr;
    logic [31:0] link_addr;
    logic        misalign;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_pc;
    logic        exp_mis;

    always #2 clk = ~clk;   // 250 MHz

    pc_word_unit u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .br_taken(br_taken),
        .br_imm(br_imm), .reg_addr(reg_addr), .fetch_addr(fetch_addr),
        .link_addr(link_addr), .misalign(misalign)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic outputs_check(input string tag);
        chk(tag, fetch_addr, exp_pc);
        chk("R9", link_addr, exp_pc + 32'd8);
        chk("R2", {30'b0, fetch_addr[1:0]}, 32'h0);
        chk("R7", {31'b0, misalign}, {31'b0, exp_mis});
    endtask

    // One clock: drive at the falling edge, predict, sample 1 ns after the rising edge
    task automatic step(input logic [1:0] s, input logic t, input logic [15:0] im,
                        input logic [31:0] ra, input logic st, input string tag);
        @(negedge clk);
        sel = s; br_taken = t; br_imm = im; reg_addr = ra; stall = st;
        exp_mis = 1'b0;
        if (!st) begin
            case (s)
                2'd1:    exp_pc = t ? exp_pc + 32'd4 + {{14{im[15]}}, im, 2'b00}
                                    : exp_pc + 32'd4;
                2'd2: begin
                    exp_pc  = ra & 32'hFFFF_FFFC;
                    exp_mis = (ra[1:0] != 2'b00);
                end
                default: exp_pc = exp_pc + 32'd4;
            endcase
        end
        @(posedge clk);
        #1;
        outputs_check(tag);
    endtask

    initial begin
        exp_pc  = 32'h0040_0000;
        exp_mis = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        outputs_check("R1");               // held in reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        outputs_check("R1");               // stalled after release

        for (int k = 0; k < 8; k++) step(2'd0, 1'b0, 16'h0, 32'h0, 1'b0, "R3");
        for (int k = 0; k < 4; k++) step(2'd3, 1'b1, 16'h1234, 32'h5, 1'b0, "R10");
        for (int k = 0; k < 16; k++)
            step(2'd1, 1'b0, 16'(k * 4099), 32'h0, 1'b0, "R5");

        // Every offset, taken; the address walks through the whole space
        for (int i = 0; i < 65536; i++) step(2'd1, 1'b1, 16'(i), 32'h0, 1'b0, "R4");
        step(2'd1, 1'b1, 16'hFFFF, 32'h0, 1'b0, "R4");   // back onto the branch itself
        step(2'd1, 1'b1, 16'h8000, 32'h0, 1'b0, "R4");   // furthest backward reach

        // Register jumps with every low-bit pattern, each followed by a sequential step
        for (int b = 0; b < 4; b++) begin
            step(2'd2, 1'b0, 16'h0, 32'h1234_5670 | 32'(b), 1'b0, "R6");
            step(2'd0, 1'b0, 16'h0, 32'h0, 1'b0, "R7");
            step(2'd2, 1'b0, 16'h0, 32'h8000_0000 | 32'(b), 1'b0, "R6");
        end

        // Stall blocks branches and misaligned jumps
        step(2'd2, 1'b0, 16'h0, 32'h0000_1003, 1'b1, "R8");
        step(2'd1, 1'b1, 16'h0100, 32'h0, 1'b1, "R8");
        step(2'd0, 1'b0, 16'h0, 32'h0, 1'b1, "R8");
        step(2'd2, 1'b0, 16'h0, 32'h0000_2001, 1'b0, "R7");
        step(2'd2, 1'b0, 16'h0, 32'h0000_3002, 1'b1, "R8");   // flag clears while stalled

        // Wrap at the top of the address space
        step(2'd2, 1'b0, 16'h0, 32'hFFFF_FFF8, 1'b0, "R11");
        step(2'd0, 1'b0, 16'h0, 32'h0, 1'b0, "R11");
        step(2'd0, 1'b0, 16'h0, 32'h0, 1'b0, "R11");
        step(2'd1, 1'b1, 16'hFFFE, 32'h0, 1'b0, "R11");

        // Asynchronous reset mid-run
        @(negedge clk);
        stall = 1'b1;
        rst_n = 1'b0;
        #0.5;
        exp_pc  = 32'h0040_0000;
        exp_mis = 1'b0;
        outputs_check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd0, 1'b0, 16'h0, 32'h0, 1'b0, "R3");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule